// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Core

This block is the digital heart of a 2 KiB serial memory that answers as a slave on a two-wire bus. It watches the clock and data lines, which reach it already synchronised to the system clock. It recognises START and STOP conditions and shifts in bytes on rising clock edges. It drives the shared data line only through an open-drain enable that pulls the line low. The first byte after a START carries a fixed four-bit device code, the three top bits of the memory address and the transfer direction.

Writes place a low address byte into an internal counter and store the following data bytes into an on-chip array. A MODE-style input decides whether a burst wraps within an aligned 8-byte window or an aligned 16-byte window. Reads return bytes from the counter for as long as the master keeps acknowledging. A sticky lock flag shields a selectable upper part of the array from writes. An internal power-on-reset input silences the whole slave while it is high.

Top module: `eep_two_wire_slave`

## Requirements
- R1: The select byte is taken MSB first. It is accepted only when its bits 7:4 are 1010. Bits 3:1 then become address bits 10:8, and bit 0 picks read (1) or write (0). Any other code gets no acknowledge and is ignored until the next START.
- R2: The slave pulls the data line low during the 9th clock after each accepted select byte, address byte and write data byte. It changes the line only while the clock is low.
- R3: START, a write select, a low address byte, one data byte and STOP store that byte at the selected address. This holds for either burst setting.
- R4: A write select, a low address byte, a repeated START and a read select return the byte stored at that address.
- R5: A read select with no address phase returns bytes starting at the internal counter. After an access, the counter points one past the last byte read, or to the next window position after the last byte written.
- R6: A read goes on while the master acknowledges each byte, and the address counter wraps from 0x7FF to 0x000. When the master does not acknowledge, the slave releases the line and waits for STOP.
- R7: During a write burst, only the low address bits step. With `burst_short` = 1 they wrap inside the aligned 8-byte window, and with `burst_short` = 0 inside the aligned 16-byte window. Extra bytes overwrite the earliest ones in that window.
- R8: The lock flag is set only by `lock_req` while `lock_en` is 1, and it stays set until reset. While it is set, a write to an address with bit 10 = 1 and bits 9:4 >= {`prot_blk`, `prot_row`} is acknowledged but not stored.
- R9: While `por` is 1, the slave never acknowledges, stores nothing and leaves the data line released.
- R10: After reset, the data line is released and the lock flag is clear, so the upper region can be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por | input | 1 | Internal power-on reset; high silences the slave |
| scl | input | 1 | Synchronised bus clock |
| sda_in | input | 1 | Synchronised bus data line as seen on the wire |
| burst_short | input | 1 | 1: 8-byte write window, 0: 16-byte write window |
| lock_en | input | 1 | Permits setting the lock flag while high |
| lock_req | input | 1 | Request to set the lock flag |
| prot_blk | input | 2 | Upper 256-byte block in which locking starts |
| prot_row | input | 4 | 16-byte row within that block at which locking starts |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The two functions that share a cycle are the acknowledge of a write data byte and the lock decision on that byte. On the same falling clock edge, the slave pulls the line low, decides whether the array is written, and steps the address within its window. The bench provokes this by sweeping every block selection and several row selections. At each boundary it writes the byte just below the lock start and the byte at it, and also writes bursts that overrun their window in both burst settings. Each case is judged by checking that every byte is acknowledged, and then by reading the region back against a memory image that the bench keeps by its own address and lock arithmetic.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int AW       = 11;
    localparam int SEL_HI_W = AW - 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef logic [AW-1:0] addr_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_ADDR,
        PH_WRITE,
        PH_READ
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Step the low lg bits of an address, holding the upper bits.
    function automatic addr_t window_step(addr_t a, int unsigned lg);
        addr_t m;
        m = addr_t'((32'd1 << lg) - 32'd1);
        return (a & ~m) | ((a + addr_t'(1)) & m);
    endfunction

    // An address is shielded when the flag is set, it lies in the upper half,
    // and its 16-byte row index reaches the selected start row.
    function automatic logic addr_locked(addr_t a, logic flag,
                                         logic [1:0] blk, logic [3:0] row);
        return flag && a[AW-1] && (a[AW-2:4] >= {blk, row});
    endfunction

endpackage

// File: rtl/eep_line_events.sv
module eep_line_events
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.rise  = !scl_q && scl;
        ev.fall  = scl_q && !scl;
        ev.start = scl_q && scl && sda_q && !sda;
        ev.stop  = scl_q && scl && !sda_q && sda;
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_BITS = 11,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic [DATA_BITS-1:0] wdata,
    output logic [DATA_BITS-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_BITS;

    logic [DATA_BITS-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/eep_lock.sv
module eep_lock (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic lock_en,
    input  logic lock_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (!por && lock_en && lock_req) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/eep_two_wire_slave.sv
module eep_two_wire_slave
    import eep_pkg::*;
#(
    parameter int SHORT_LG = 3,
    parameter int LONG_LG  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic       scl,
    input  logic       sda_in,
    input  logic       burst_short,
    input  logic       lock_en,
    input  logic       lock_req,
    input  logic [1:0] prot_blk,
    input  logic [3:0] prot_row,
    output logic       sda_oe
);
    bus_ev_t    ev;
    phase_e     phase;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       rd_mode;
    logic       master_ack;
    addr_t      addr;
    logic       prot_flag;
    logic       mem_we;
    logic [7:0] mem_q;
    logic       sel_match;
    logic       wr_blocked;

    eep_line_events u_events (
        .clk (clk),
        .rst (rst),
        .scl (scl),
        .sda (sda_in),
        .ev  (ev)
    );

    eep_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .por      (por),
        .lock_en  (lock_en),
        .lock_req (lock_req),
        .flag     (prot_flag)
    );

    eep_array #(.ADDR_BITS(AW), .DATA_BITS(8)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (addr),
        .wdata (shreg),
        .rdata (mem_q)
    );

    assign sel_match  = (shreg[7:4] == DEV_CODE);
    assign wr_blocked = addr_locked(addr, prot_flag, prot_blk, prot_row);
    assign mem_we     = !por && (phase == PH_WRITE) && ev.fall
                        && (bit_cnt == 4'd8) && !wr_blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            bit_cnt    <= 4'd0;
            shreg      <= 8'd0;
            rd_mode    <= 1'b0;
            master_ack <= 1'b0;
            addr       <= '0;
            sda_oe     <= 1'b0;
        end else if (por) begin
            phase   <= PH_IDLE;
            bit_cnt <= 4'd0;
            sda_oe  <= 1'b0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            phase   <= PH_SEL;
            bit_cnt <= 4'd0;
            sda_oe  <= 1'b0;
        end else if (phase != PH_IDLE) begin
            if (ev.rise) begin
                if (bit_cnt < 4'd8) begin
                    bit_cnt <= bit_cnt + 4'd1;
                    if (phase != PH_READ) begin
                        shreg <= {shreg[6:0], sda_in};
                    end
                end else if (bit_cnt == 4'd8) begin
                    bit_cnt <= 4'd9;
                    if (phase == PH_READ) begin
                        master_ack <= !sda_in;
                        addr       <= addr + addr_t'(1);
                    end
                end
            end else if (ev.fall) begin
                case (phase)
                    PH_SEL: begin
                        if (bit_cnt == 4'd8) begin
                            if (sel_match) begin
                                sda_oe  <= 1'b1;
                                rd_mode <= shreg[0];
                                addr[AW-1 -: SEL_HI_W] <= shreg[SEL_HI_W:1];
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else if (bit_cnt == 4'd9) begin
                            bit_cnt <= 4'd0;
                            if (rd_mode) begin
                                phase  <= PH_READ;
                                sda_oe <= !mem_q[7];
                            end else begin
                                phase  <= PH_ADDR;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_ADDR: begin
                        if (bit_cnt == 4'd8) begin
                            sda_oe    <= 1'b1;
                            addr[7:0] <= shreg;
                        end else if (bit_cnt == 4'd9) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= 4'd0;
                            phase   <= PH_WRITE;
                        end
                    end
                    PH_WRITE: begin
                        if (bit_cnt == 4'd8) begin
                            sda_oe <= 1'b1;
                            addr   <= window_step(addr, burst_short ? SHORT_LG : LONG_LG);
                        end else if (bit_cnt == 4'd9) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= 4'd0;
                        end
                    end
                    PH_READ: begin
                        if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
                            sda_oe <= !mem_q[3'd7 - bit_cnt[2:0]];
                        end else if (bit_cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                        end else if (bit_cnt == 4'd9) begin
                            if (master_ack) begin
                                bit_cnt <= 4'd0;
                                sda_oe  <= !mem_q[7];
                            end else begin
                                phase  <= PH_IDLE;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
    import eep_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  por,
    input logic  scl,
    input logic  lock_en,
    input logic  sda_oe,
    input logic  prot_flag,
    input logic  mem_we,
    input addr_t addr
);
    assert_por_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        por |=> !sda_oe);

    assert_ack_on_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl));

    assert_lock_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_flag) |-> $past(lock_en));

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        prot_flag |=> prot_flag);

    assert_burst_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (addr[AW-1:4] == $past(addr[AW-1:4])));
endmodule

bind eep_two_wire_slave eep_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .por       (por),
    .scl       (scl),
    .lock_en   (lock_en),
    .sda_oe    (sda_oe),
    .prot_flag (prot_flag),
    .mem_we    (mem_we),
    .addr      (addr)
);

// File: tb/eep_two_wire_slave_bench.sv
module eep_two_wire_slave_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       por;
    logic       scl;
    logic       md;
    logic       burst_short;
    logic       lock_en;
    logic       lock_req;
    logic [1:0] prot_blk;
    logic [3:0] prot_row;
    logic       sda_oe;
    logic       sda_line;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    bit   flag_exp = 1'b0;
    int   cur_exp = 0;
    logic [7:0] model [2048];

    always #10 clk = ~clk;

    assign sda_line = md & !sda_oe;

    eep_two_wire_slave u_eep_two_wire_slave (
        .clk         (clk),
        .rst         (rst),
        .por         (por),
        .scl         (scl),
        .sda_in      (sda_line),
        .burst_short (burst_short),
        .lock_en     (lock_en),
        .lock_req    (lock_req),
        .prot_blk    (prot_blk),
        .prot_row    (prot_row),
        .sda_oe      (sda_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        md = 1'b1; tick();
        scl = 1'b1; tick();
        md = 1'b0; tick();
        scl = 1'b0; tick();
    endtask

    task automatic bus_stop();
        md = 1'b0; tick();
        scl = 1'b1; tick();
        md = 1'b1; tick();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            md = b[i]; tick();
            scl = 1'b1; tick();
            scl = 1'b0;
        end
        tick();
        md = 1'b1; tick();
        scl = 1'b1; tick();
        acked = !sda_line;
        scl = 1'b0; tick();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        md = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick();
            scl = 1'b1; tick();
            b[i] = sda_line;
            scl = 1'b0;
        end
        tick();
        md = give_ack ? 1'b0 : 1'b1; tick();
        scl = 1'b1; tick();
        scl = 1'b0; tick();
        md = 1'b1;
    endtask

    function automatic logic [7:0] sel_byte(input int a, input logic rd);
        return {4'b1010, 3'((a >> 8) & 7), rd};
    endfunction

    function automatic bit locked_exp(input int a);
        return flag_exp && (a >= 1024)
               && (((a >> 4) & 63) >= (int'(prot_blk) * 16 + int'(prot_row)));
    endfunction

    function automatic int step_exp(input int a);
        int w;
        w = burst_short ? 8 : 16;
        return (a / w) * w + ((a % w) + 1) % w;
    endfunction

    task automatic write_seq(input int a, input int n, input int seed, input string tag);
        logic ak;
        bit   all_ok;
        int   pos;
        logic [7:0] d;
        all_ok = 1'b1;
        bus_start();
        send_byte(sel_byte(a, 1'b0), ak);
        chk(ak === 1'b1, "R2", int'(ak), 1);
        send_byte(8'(a & 255), ak);
        all_ok &= (ak === 1'b1);
        pos = a;
        for (int k = 0; k < n; k++) begin
            d = 8'(seed + k * 37);
            send_byte(d, ak);
            all_ok &= (ak === 1'b1);
            if (!locked_exp(pos)) model[pos] = d;
            pos = step_exp(pos);
        end
        bus_stop();
        cur_exp = pos;
        chk(all_ok, tag, int'(all_ok), 1);
    endtask

    task automatic read_seq(input int a, input int n, input bit with_addr, input string tag);
        logic ak;
        logic [7:0] got;
        int   idx;
        bus_start();
        if (with_addr) begin
            send_byte(sel_byte(a, 1'b0), ak);
            send_byte(8'(a & 255), ak);
            bus_start();
        end
        send_byte(sel_byte(a, 1'b1), ak);
        chk(ak === 1'b1, tag, int'(ak), 1);
        for (int k = 0; k < n; k++) begin
            idx = (a + k) % 2048;
            recv_byte(k != n - 1, got);
            chk(got === model[idx], tag, int'(got), int'(model[idx]));
        end
        chk(sda_line === 1'b1, "R6", int'(sda_line), 1);
        bus_stop();
        cur_exp = (a + n) % 2048;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic ak;
        int   bnd;
        rst = 1'b1; por = 1'b0; scl = 1'b1; md = 1'b1;
        burst_short = 1'b0; lock_en = 1'b0; lock_req = 1'b0;
        prot_blk = 2'd0; prot_row = 4'd0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        tick();

        // R10: line released after reset
        chk(sda_line === 1'b1 && sda_oe === 1'b0, "R10", int'(sda_oe), 0);

        // R1: a foreign device code is not acknowledged
        bus_start();
        send_byte(8'h90, ak);
        chk(ak === 1'b0, "R1", int'(ak), 0);
        send_byte(8'h12, ak);
        chk(ak === 1'b0, "R1", int'(ak), 0);
        bus_stop();

        // R3 / R1: single bytes, select bits 3:1 carry address bits 10:8
        write_seq(12'h0F0, 1, 8'h11, "R3");
        burst_short = 1'b1;
        write_seq(12'h6F0, 1, 8'h22, "R3");
        read_seq(12'h0F0, 1, 1'b1, "R1");
        read_seq(12'h6F0, 1, 1'b1, "R1");

        // R4 / R5: random read, then reads from the counter
        burst_short = 1'b0;
        write_seq(12'h120, 16, 8'h40, "R3");
        read_seq(12'h123, 1, 1'b1, "R4");
        read_seq(cur_exp, 2, 1'b0, "R5");

        // R6: sequential read across the top of the array
        write_seq(12'h7FE, 2, 8'h70, "R3");
        write_seq(12'h000, 3, 8'h90, "R3");
        read_seq(12'h7FE, 4, 1'b1, "R6");
        chk(cur_exp == 2, "R6", cur_exp, 2);
        read_seq(cur_exp, 1, 1'b0, "R5");

        // R7: bursts overrunning their window in both settings
        for (int ms = 0; ms < 2; ms++) begin
            for (int oi = 0; oi < 2; oi++) begin
                int w;
                int base;
                burst_short = ms[0];
                w = ms ? 8 : 16;
                base = 12'h200 + ms * 12'h40 + oi * 12'h20;
                write_seq(base + oi * 5, w + 3, 8'h30 + ms * 16 + oi, "R7");
                chk(cur_exp == base + ((oi * 5 + w + 3) % w), "R7", cur_exp,
                    base + ((oi * 5 + w + 3) % w));
                read_seq(base, w, 1'b1, "R7");
            end
        end

        // R10: flag clear after reset, upper region writable
        burst_short = 1'b0;
        write_seq(12'h7F8, 1, 8'hC3, "R10");
        read_seq(12'h7F8, 1, 1'b1, "R10");

        // preload every boundary pair with the flag clear
        for (int b = 0; b < 4; b++) begin
            for (int ri = 0; ri < 3; ri++) begin
                bnd = 1024 + b * 256 + (ri == 0 ? 0 : (ri == 1 ? 7 : 15)) * 16;
                write_seq(bnd - 1, 1, 8'h05 + b * 3 + ri, "R3");
                write_seq(bnd, 1, 8'h55 + b * 3 + ri, "R3");
            end
        end

        // R8: request without enable leaves the flag clear
        @(negedge clk); lock_req = 1'b1;
        @(negedge clk); lock_req = 1'b0;
        write_seq(12'h7A0, 1, 8'hA7, "R8");
        read_seq(12'h7A0, 1, 1'b1, "R8");

        // R8: arm the flag, then sweep boundaries
        @(negedge clk); lock_en = 1'b1; lock_req = 1'b1;
        @(negedge clk); lock_en = 1'b0; lock_req = 1'b0;
        flag_exp = 1'b1;
        for (int b = 0; b < 4; b++) begin
            for (int ri = 0; ri < 3; ri++) begin
                prot_blk = 2'(b);
                prot_row = (ri == 0) ? 4'd0 : ((ri == 1) ? 4'd7 : 4'd15);
                bnd = 1024 + b * 256 + int'(prot_row) * 16;
                write_seq(bnd - 1, 1, 8'hD0 + b * 3 + ri, "R8");
                write_seq(bnd, 1, 8'hE0 + b * 3 + ri, "R8");
                read_seq(bnd - 1, 2, 1'b1, "R8");
            end
        end

        // R9: power-on reset silences the slave
        write_seq(12'h050, 1, 8'h3C, "R3");
        @(negedge clk); por = 1'b1;
        bus_start();
        send_byte(sel_byte(12'h050, 1'b0), ak);
        chk(ak === 1'b0, "R9", int'(ak), 0);
        send_byte(8'h50, ak);
        send_byte(8'hEE, ak);
        chk(ak === 1'b0, "R9", int'(ak), 0);
        bus_stop();
        @(negedge clk); por = 1'b0;
        tick();
        read_seq(12'h050, 1, 1'b1, "R9");

        done = 1'b1;
        finish_run();
    end

endmodule